// File: doc/BRIEF.md
# TCP Echo Application Engine

This block is the application-side partner of a hardware TCP offload engine and turns it into an echo server. After reset it asks the engine to listen on one fixed port. It then waits for notifications. A data notification causes it to fetch the announced bytes for that session, buffer them, ask the engine for transmit space, and return the same bytes on the same session. A refused space query is repeated after a programmable pause. Close notifications and empty notifications are consumed and cause no other activity.

Every channel is a valid/ready stream. Only one transfer is in flight at a time. A notification that announces more bytes than the local buffer can hold is handled in buffer-sized chunks. Each chunk is fetched, queried and echoed before the next one is requested. The notification fields that the echo function does not use (peer address, destination port) and the remaining-space field of the transmit response are not brought into the block.

Top module: `tcp_echo_engine`

## Requirements
- R1: After reset the block drives exactly one listen request carrying the port `LISTEN_PORT` (range 0 to 32767). It accepts no notification until the listen response has been taken.
- R2: A listen response of 0 raises `listen_failed`, which stays high until reset. From then on no further listen request is made and no notification is ever accepted.
- R3: A notification with the closed flag at 1, or with a length of 0, is accepted and causes no read request. The block is ready for the next notification in the following cycle.
- R4: A data notification with length L produces read requests for its session with length min(remaining, `BUF_BYTES`). Each later chunk is requested only after the previous chunk has been fully echoed. The chunk lengths add up to L.
- R5: After a read request the block takes one receive-metadata item, then payload beats up to and including the beat with last=1. It then issues a transmit query with the metadata session and the chunk length.
- R6: A transmit response counts as positive only when its 2-bit error field is 0. No transmit payload beat is offered before a positive response to the current query.
- R7: A transmit response with a nonzero error field causes the same session and length to be queried again. The new query becomes valid exactly N+1 cycles after the response handshake, where N is `backoff_cycles`.
- R8: The echoed beats equal the received beats of the chunk in data, keep mask and order. last is 1 only on the final beat of the chunk.
- R9: From the accepted data notification until the final beat of its last chunk, `ntf_ready` stays low. It is high in the cycle right after that final beat, and in the cycle right after a positive listen response.
- R10: A chunk of exactly `BUF_BYTES` bytes fills the buffer without overflow. The engine never sends more beats than the chunk it was asked for.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| backoff_cycles | input | BO_W | Pause N before repeating a refused transmit query |
| lsn_req_valid | output | 1 | Listen request valid |
| lsn_req_ready | input | 1 | Listen request accepted |
| lsn_req_port | output | 16 | Port to listen on |
| lsn_rsp_valid | input | 1 | Listen response valid |
| lsn_rsp_ready | output | 1 | Listen response accepted |
| lsn_rsp_ok | input | 1 | 1 = port entered listen state |
| ntf_valid | input | 1 | Notification valid |
| ntf_ready | output | 1 | Notification accepted |
| ntf_session | input | 16 | Session of the notification |
| ntf_length | input | 16 | Bytes available |
| ntf_closed | input | 1 | 1 = connection closed |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_session | output | 16 | Session to read |
| rd_req_length | output | 16 | Bytes to read |
| rx_meta_valid | input | 1 | Receive metadata valid |
| rx_meta_ready | output | 1 | Receive metadata accepted |
| rx_meta_session | input | 16 | Session of the arriving payload |
| rx_valid | input | 1 | Receive beat valid |
| rx_ready | output | 1 | Receive beat accepted |
| rx_data | input | DATA_W | Receive beat data |
| rx_keep | input | DATA_W/8 | Receive byte mask |
| rx_last | input | 1 | Final receive beat |
| tx_meta_valid | output | 1 | Transmit query valid |
| tx_meta_ready | input | 1 | Transmit query accepted |
| tx_meta_session | output | 16 | Session to transmit on |
| tx_meta_length | output | 16 | Bytes to transmit |
| tx_rsp_valid | input | 1 | Transmit response valid |
| tx_rsp_ready | output | 1 | Transmit response accepted |
| tx_rsp_error | input | 2 | 0 = space granted, other = refused |
| tx_valid | output | 1 | Transmit beat valid |
| tx_ready | input | 1 | Transmit beat accepted |
| tx_data | output | DATA_W | Transmit beat data |
| tx_keep | output | DATA_W/8 | Transmit byte mask |
| tx_last | output | 1 | Final transmit beat |
| listen_failed | output | 1 | Sticky listen failure |

## Verification
Two events can meet in one cycle: the listen response arriving and a data notification already waiting on its channel. The bench raises the notification before it answers the listen request. It then checks that `ntf_ready` is low while the listen response is handshaken and high on the very next cycle. The same kind of check is applied at the end of every transfer, with the notification channel observed across the final transmit beat. A sweep over notification lengths from 1 to 40 against a 16-byte buffer combines partial keep masks, single and multiple chunks, zero to two refusals and four pause values. Every beat and every pause is predicted arithmetically.

// File: rtl/tcp_echo_pkg.sv
package tcp_echo_pkg;
  localparam int NST = 12;
  localparam int S_LREQ   = 0;
  localparam int S_LRSP   = 1;
  localparam int S_DEAD   = 2;
  localparam int S_IDLE   = 3;
  localparam int S_RDREQ  = 4;
  localparam int S_RXMETA = 5;
  localparam int S_RXDATA = 6;
  localparam int S_TXMETA = 7;
  localparam int S_TXRSP  = 8;
  localparam int S_BACKOFF = 9;
  localparam int S_TXRD   = 10;
  localparam int S_TXOUT  = 11;

  typedef logic [NST-1:0] state_t;

  function automatic state_t st_bit(input int idx);
    return state_t'(1) << idx;
  endfunction
endpackage

// File: rtl/echo_payload_buf.sv
module echo_payload_buf #(
  parameter int WIDTH = 72,
  parameter int DEPTH = 256,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/echo_backoff_timer.sv
module echo_backoff_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - CNT_W'(1);
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/echo_ctrl.sv
module echo_ctrl
  import tcp_echo_pkg::*;
#(
  parameter int BUF_BYTES = 2048,
  parameter int DEPTH     = 256,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam logic [15:0] BUF_LEN = 16'(BUF_BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  output logic          lsn_req_valid,
  input  logic          lsn_req_ready,
  input  logic          lsn_rsp_valid,
  output logic          lsn_rsp_ready,
  input  logic          lsn_rsp_ok,
  input  logic          ntf_valid,
  output logic          ntf_ready,
  input  logic [15:0]   ntf_session,
  input  logic [15:0]   ntf_length,
  input  logic          ntf_closed,
  output logic          rd_req_valid,
  input  logic          rd_req_ready,
  output logic [15:0]   rd_req_session,
  output logic [15:0]   rd_req_length,
  input  logic          rx_meta_valid,
  output logic          rx_meta_ready,
  input  logic [15:0]   rx_meta_session,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic          rx_last,
  output logic          tx_meta_valid,
  input  logic          tx_meta_ready,
  output logic [15:0]   tx_meta_session,
  output logic [15:0]   tx_meta_length,
  input  logic          tx_rsp_valid,
  output logic          tx_rsp_ready,
  input  logic [1:0]    tx_rsp_error,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic          tx_last,
  output logic          listen_failed,
  output logic          bo_load,
  input  logic          bo_expired,
  output logic          buf_we,
  output logic [AW-1:0] buf_waddr,
  output logic          buf_re,
  output logic [AW-1:0] buf_raddr
);
  state_t      st_q, st_d;
  logic        failed_q;
  logic [15:0] sess_q, rxs_q, rem_q, chunk;
  logic [AW-1:0] wr_ptr, last_ptr, rd_ptr;
  logic        at_last, rsp_ok, rsp_hs;

  // Handshake outputs are bits of the one-hot state register.
  assign lsn_req_valid = st_q[S_LREQ];
  assign lsn_rsp_ready = st_q[S_LRSP];
  assign ntf_ready     = st_q[S_IDLE];
  assign rd_req_valid  = st_q[S_RDREQ];
  assign rx_meta_ready = st_q[S_RXMETA];
  assign rx_ready      = st_q[S_RXDATA];
  assign tx_meta_valid = st_q[S_TXMETA];
  assign tx_rsp_ready  = st_q[S_TXRSP];
  assign tx_valid      = st_q[S_TXOUT];
  assign listen_failed = failed_q;

  assign chunk          = (rem_q > BUF_LEN) ? BUF_LEN : rem_q;
  assign rd_req_session = sess_q;
  assign rd_req_length  = chunk;
  assign tx_meta_session = rxs_q;
  assign tx_meta_length  = chunk;

  assign at_last = (rd_ptr == last_ptr);
  assign tx_last = st_q[S_TXOUT] && at_last;
  assign rsp_hs  = st_q[S_TXRSP] && tx_rsp_valid;
  assign rsp_ok  = (tx_rsp_error == 2'd0);
  assign bo_load = rsp_hs && !rsp_ok;

  assign buf_we    = st_q[S_RXDATA] && rx_valid;
  assign buf_waddr = wr_ptr;
  assign buf_re    = st_q[S_TXRD];
  assign buf_raddr = rd_ptr;

  always_comb begin
    st_d = st_q;
    case (1'b1)
      st_q[S_LREQ]:    if (lsn_req_ready) st_d = st_bit(S_LRSP);
      st_q[S_LRSP]:    if (lsn_rsp_valid) st_d = lsn_rsp_ok ? st_bit(S_IDLE) : st_bit(S_DEAD);
      st_q[S_IDLE]:    if (ntf_valid && !ntf_closed && ntf_length != 16'd0) st_d = st_bit(S_RDREQ);
      st_q[S_RDREQ]:   if (rd_req_ready) st_d = st_bit(S_RXMETA);
      st_q[S_RXMETA]:  if (rx_meta_valid) st_d = st_bit(S_RXDATA);
      st_q[S_RXDATA]:  if (rx_valid && rx_last) st_d = st_bit(S_TXMETA);
      st_q[S_TXMETA]:  if (tx_meta_ready) st_d = st_bit(S_TXRSP);
      st_q[S_TXRSP]:   if (tx_rsp_valid) st_d = rsp_ok ? st_bit(S_TXRD) : st_bit(S_BACKOFF);
      st_q[S_BACKOFF]: if (bo_expired) st_d = st_bit(S_TXMETA);
      st_q[S_TXRD]:    st_d = st_bit(S_TXOUT);
      st_q[S_TXOUT]: begin
        if (tx_ready) begin
          if (!at_last)            st_d = st_bit(S_TXRD);
          else if (rem_q == chunk) st_d = st_bit(S_IDLE);
          else                     st_d = st_bit(S_RDREQ);
        end
      end
      default: st_d = st_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= st_bit(S_LREQ);
    else     st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      failed_q <= 1'b0;
      sess_q   <= '0;
      rxs_q    <= '0;
      rem_q    <= '0;
      wr_ptr   <= '0;
      last_ptr <= '0;
      rd_ptr   <= '0;
    end else begin
      if (st_q[S_LRSP] && lsn_rsp_valid && !lsn_rsp_ok) failed_q <= 1'b1;
      if (st_q[S_IDLE] && ntf_valid) begin
        sess_q <= ntf_session;
        rem_q  <= ntf_length;
      end
      if (st_q[S_RXMETA] && rx_meta_valid) begin
        rxs_q  <= rx_meta_session;
        wr_ptr <= '0;
      end
      if (buf_we) begin
        wr_ptr <= wr_ptr + AW'(1);
        if (rx_last) last_ptr <= wr_ptr;
      end
      if (rsp_hs && rsp_ok) rd_ptr <= '0;
      if (st_q[S_TXOUT] && tx_ready) begin
        if (at_last) rem_q  <= rem_q - chunk;
        else         rd_ptr <= rd_ptr + AW'(1);
      end
    end
  end

  a_r1_listen_once: assert property (@(posedge clk) disable iff (rst)
    (lsn_req_valid && lsn_req_ready) |=> !lsn_req_valid);

  a_r2_failed_sticky: assert property (@(posedge clk) disable iff (rst)
    listen_failed |=> listen_failed);

  a_r2_no_notif_after_fail: assert property (@(posedge clk) disable iff (rst)
    listen_failed |-> (!ntf_ready && !lsn_req_valid));

  a_r4_chunk_bound: assert property (@(posedge clk) disable iff (rst)
    rd_req_valid |-> (rd_req_length != 16'd0 && rd_req_length <= BUF_LEN));

  a_r7_query_hold: assert property (@(posedge clk) disable iff (rst)
    (tx_meta_valid && !tx_meta_ready) |=>
      (tx_meta_valid && $stable(tx_meta_length) && $stable(tx_meta_session)));

  a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_ready && !rx_last) |-> (wr_ptr != AW'(DEPTH - 1)));
endmodule

// File: rtl/tcp_echo_engine.sv
module tcp_echo_engine #(
  parameter int DATA_W      = 64,
  parameter int BUF_BYTES   = 2048,
  parameter int LISTEN_PORT = 7,
  parameter int BO_W        = 16,
  localparam int KEEP_W = DATA_W / 8,
  localparam int DEPTH  = BUF_BYTES / KEEP_W,
  localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int MEM_W  = DATA_W + KEEP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BO_W-1:0]   backoff_cycles,
  output logic              lsn_req_valid,
  input  logic              lsn_req_ready,
  output logic [15:0]       lsn_req_port,
  input  logic              lsn_rsp_valid,
  output logic              lsn_rsp_ready,
  input  logic              lsn_rsp_ok,
  input  logic              ntf_valid,
  output logic              ntf_ready,
  input  logic [15:0]       ntf_session,
  input  logic [15:0]       ntf_length,
  input  logic              ntf_closed,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [15:0]       rd_req_session,
  output logic [15:0]       rd_req_length,
  input  logic              rx_meta_valid,
  output logic              rx_meta_ready,
  input  logic [15:0]       rx_meta_session,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [KEEP_W-1:0] rx_keep,
  input  logic              rx_last,
  output logic              tx_meta_valid,
  input  logic              tx_meta_ready,
  output logic [15:0]       tx_meta_session,
  output logic [15:0]       tx_meta_length,
  input  logic              tx_rsp_valid,
  output logic              tx_rsp_ready,
  input  logic [1:0]        tx_rsp_error,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  output logic [KEEP_W-1:0] tx_keep,
  output logic              tx_last,
  output logic              listen_failed
);
  logic          bo_load, bo_expired;
  logic          buf_we, buf_re;
  logic [AW-1:0] buf_waddr, buf_raddr;
  logic [MEM_W-1:0] buf_rdata;

  initial begin
    a_r1_port_range: assert (LISTEN_PORT >= 0 && LISTEN_PORT <= 32767)
      else $error("listen port out of range");
  end

  assign lsn_req_port = 16'(LISTEN_PORT);

  echo_ctrl #(
    .BUF_BYTES (BUF_BYTES),
    .DEPTH     (DEPTH)
  ) u_ctrl (
    .clk             (clk),
    .rst             (rst),
    .lsn_req_valid   (lsn_req_valid),
    .lsn_req_ready   (lsn_req_ready),
    .lsn_rsp_valid   (lsn_rsp_valid),
    .lsn_rsp_ready   (lsn_rsp_ready),
    .lsn_rsp_ok      (lsn_rsp_ok),
    .ntf_valid       (ntf_valid),
    .ntf_ready       (ntf_ready),
    .ntf_session     (ntf_session),
    .ntf_length      (ntf_length),
    .ntf_closed      (ntf_closed),
    .rd_req_valid    (rd_req_valid),
    .rd_req_ready    (rd_req_ready),
    .rd_req_session  (rd_req_session),
    .rd_req_length   (rd_req_length),
    .rx_meta_valid   (rx_meta_valid),
    .rx_meta_ready   (rx_meta_ready),
    .rx_meta_session (rx_meta_session),
    .rx_valid        (rx_valid),
    .rx_ready        (rx_ready),
    .rx_last         (rx_last),
    .tx_meta_valid   (tx_meta_valid),
    .tx_meta_ready   (tx_meta_ready),
    .tx_meta_session (tx_meta_session),
    .tx_meta_length  (tx_meta_length),
    .tx_rsp_valid    (tx_rsp_valid),
    .tx_rsp_ready    (tx_rsp_ready),
    .tx_rsp_error    (tx_rsp_error),
    .tx_valid        (tx_valid),
    .tx_ready        (tx_ready),
    .tx_last         (tx_last),
    .listen_failed   (listen_failed),
    .bo_load         (bo_load),
    .bo_expired      (bo_expired),
    .buf_we          (buf_we),
    .buf_waddr       (buf_waddr),
    .buf_re          (buf_re),
    .buf_raddr       (buf_raddr)
  );

  echo_backoff_timer #(.CNT_W(BO_W)) u_backoff (
    .clk      (clk),
    .rst      (rst),
    .load     (bo_load),
    .load_val (backoff_cycles),
    .expired  (bo_expired)
  );

  echo_payload_buf #(.WIDTH(MEM_W), .DEPTH(DEPTH)) u_buf (
    .clk   (clk),
    .we    (buf_we),
    .waddr (buf_waddr),
    .wdata ({rx_keep, rx_data}),
    .re    (buf_re),
    .raddr (buf_raddr),
    .rdata (buf_rdata)
  );

  assign tx_data = buf_rdata[DATA_W-1:0];
  assign tx_keep = buf_rdata[MEM_W-1:DATA_W];

  a_r8_beat_hold: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_keep)));
endmodule

// File: tb/test_tcp_echo_engine.sv
module test_tcp_echo_engine;
  localparam int CLK_PERIOD = 10;
  localparam int DW   = 32;
  localparam int KB   = DW / 8;
  localparam int BUFB = 16;
  localparam int PORT = 7777;
  localparam int BOW  = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic [BOW-1:0] backoff_cycles = '0;
  logic lsn_req_valid, lsn_req_ready = 1'b0;
  logic [15:0] lsn_req_port;
  logic lsn_rsp_valid = 1'b0, lsn_rsp_ready, lsn_rsp_ok = 1'b0;
  logic ntf_valid = 1'b0, ntf_ready, ntf_closed = 1'b0;
  logic [15:0] ntf_session = '0, ntf_length = '0;
  logic rd_req_valid, rd_req_ready = 1'b0;
  logic [15:0] rd_req_session, rd_req_length;
  logic rx_meta_valid = 1'b0, rx_meta_ready;
  logic [15:0] rx_meta_session = '0;
  logic rx_valid = 1'b0, rx_ready, rx_last = 1'b0;
  logic [DW-1:0] rx_data = '0;
  logic [KB-1:0] rx_keep = '0;
  logic tx_meta_valid, tx_meta_ready = 1'b0;
  logic [15:0] tx_meta_session, tx_meta_length;
  logic tx_rsp_valid = 1'b0, tx_rsp_ready;
  logic [1:0] tx_rsp_error = '0;
  logic tx_valid, tx_ready = 1'b0, tx_last;
  logic [DW-1:0] tx_data;
  logic [KB-1:0] tx_keep;
  logic listen_failed;

  int checks = 0, fails = 0;
  bit busy = 1'b0, tx_open = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tcp_echo_engine #(
    .DATA_W(DW), .BUF_BYTES(BUFB), .LISTEN_PORT(PORT), .BO_W(BOW)
  ) i_tcp_echo_engine (
    .clk(clk), .rst(rst), .backoff_cycles(backoff_cycles),
    .lsn_req_valid(lsn_req_valid), .lsn_req_ready(lsn_req_ready), .lsn_req_port(lsn_req_port),
    .lsn_rsp_valid(lsn_rsp_valid), .lsn_rsp_ready(lsn_rsp_ready), .lsn_rsp_ok(lsn_rsp_ok),
    .ntf_valid(ntf_valid), .ntf_ready(ntf_ready), .ntf_session(ntf_session),
    .ntf_length(ntf_length), .ntf_closed(ntf_closed),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_session(rd_req_session), .rd_req_length(rd_req_length),
    .rx_meta_valid(rx_meta_valid), .rx_meta_ready(rx_meta_ready), .rx_meta_session(rx_meta_session),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_keep(rx_keep), .rx_last(rx_last),
    .tx_meta_valid(tx_meta_valid), .tx_meta_ready(tx_meta_ready),
    .tx_meta_session(tx_meta_session), .tx_meta_length(tx_meta_length),
    .tx_rsp_valid(tx_rsp_valid), .tx_rsp_ready(tx_rsp_ready), .tx_rsp_error(tx_rsp_error),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_keep(tx_keep), .tx_last(tx_last),
    .listen_failed(listen_failed)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int t, input int c, input int b);
    return DW'(t * 16777619 + c * 40503 + b * 2654435 + 90);
  endfunction

  function automatic logic [KB-1:0] kmask(input int ch, input int b);
    int n = ch - b * KB;
    if (n >= KB) return '1;
    return KB'((1 << n) - 1);
  endfunction

  // R6: no payload beat before a positive response; R9: notifications held off while busy
  always @(negedge clk) begin
    if (!rst && tx_valid && !tx_open) begin
      checks++; fails++;
      $display("FAIL R6 tx beat before grant actual=1 expected=0");
    end
    if (!rst && busy && ntf_ready) begin
      checks++; fails++;
      $display("FAIL R9 notification ready while busy actual=1 expected=0");
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic send_notif(input logic [15:0] s, input int len, input bit closed, input bit mark_busy);
    ntf_session = s; ntf_length = 16'(len); ntf_closed = closed; ntf_valid = 1'b1;
    while (!ntf_ready) tick();
    tick();
    ntf_valid = 1'b0;
    busy = mark_busy;
  endtask

  task automatic take_rdreq(input logic [15:0] s, input int len);
    while (!rd_req_valid) tick();
    chk(rd_req_session == s, "R4 read session", rd_req_session, s);
    chk(rd_req_length == 16'(len), "R4 read length", rd_req_length, len);
    rd_req_ready = 1'b1; tick(); rd_req_ready = 1'b0;
  endtask

  task automatic give_rxmeta(input logic [15:0] s);
    rx_meta_session = s; rx_meta_valid = 1'b1;
    while (!rx_meta_ready) tick();
    tick(); rx_meta_valid = 1'b0;
  endtask

  task automatic give_beat(input logic [DW-1:0] d, input logic [KB-1:0] k, input bit l);
    rx_data = d; rx_keep = k; rx_last = l; rx_valid = 1'b1;
    while (!rx_ready) tick();
    tick(); rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  task automatic take_txmeta(input logic [15:0] s, input int len, input string req);
    while (!tx_meta_valid) tick();
    chk(tx_meta_session == s, req, tx_meta_session, s);
    chk(tx_meta_length == 16'(len), req, tx_meta_length, len);
    tx_meta_ready = 1'b1; tick(); tx_meta_ready = 1'b0;
  endtask

  task automatic give_txrsp(input logic [1:0] e);
    tx_rsp_error = e; tx_rsp_valid = 1'b1;
    while (!tx_rsp_ready) tick();
    tick(); tx_rsp_valid = 1'b0;
  endtask

  task automatic take_txbeat(input logic [DW-1:0] d, input logic [KB-1:0] k, input bit l);
    while (!tx_valid) tick();
    chk(tx_data == d, "R8 echo data", tx_data, d);
    chk(tx_keep == k, "R8 echo keep", tx_keep, k);
    chk(tx_last == l, "R8 echo last", tx_last, l);
    tx_ready = 1'b1; tick(); tx_ready = 1'b0;
  endtask

  task automatic echo_body(input int t, input logic [15:0] s, input int len, input int nref, input int bo);
    int rem = len;
    int c = 0;
    while (rem > 0) begin
      int ch = (rem > BUFB) ? BUFB : rem;
      int nb = (ch + KB - 1) / KB;
      take_rdreq(s, ch);
      give_rxmeta(s);
      for (int b = 0; b < nb; b++) give_beat(pat(t, c, b), kmask(ch, b), b == nb - 1);
      for (int r = 0; r < nref; r++) begin
        int k = 0;
        take_txmeta(s, ch, (r == 0) ? "R5 first query" : "R7 repeated query");
        give_txrsp(2'((r % 3) + 1));
        while (!tx_meta_valid && k < 1000) begin tick(); k++; end
        chk(k == bo + 1, "R7 back-off distance", k, bo + 1);
      end
      take_txmeta(s, ch, (nref == 0) ? "R5 first query" : "R7 repeated query");
      give_txrsp(2'd0);
      tx_open = 1'b1;
      for (int b = 0; b < nb; b++) take_txbeat(pat(t, c, b), kmask(ch, b), b == nb - 1);
      tx_open = 1'b0;
      rem -= ch;
      c++;
      if (rem > 0) chk(ntf_ready == 1'b0, "R4 next chunk before idle", ntf_ready, 0);
    end
    busy = 1'b0;
    chk(ntf_ready == 1'b1, "R9 ready right after final beat", ntf_ready, 1);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state
    chk(lsn_req_valid == 1'b1, "R1 listen request after reset", lsn_req_valid, 1);
    chk(lsn_req_port == 16'(PORT), "R1 listen port", lsn_req_port, PORT);
    chk(listen_failed == 1'b0, "R2 no failure at reset", listen_failed, 0);
    chk(ntf_ready == 1'b0, "R1 no notification before listen", ntf_ready, 0);
    chk(rd_req_valid == 1'b0 && tx_meta_valid == 1'b0 && tx_valid == 1'b0,
        "R1 quiet channels", {rd_req_valid, tx_meta_valid, tx_valid}, 0);

    // Pending notification while the listen response arrives (R9)
    ntf_session = 16'h0101; ntf_length = 16'd5; ntf_closed = 1'b0; ntf_valid = 1'b1;
    backoff_cycles = 8'd2;
    tick(); tick();
    chk(ntf_ready == 1'b0, "R1 notification held during listen", ntf_ready, 0);
    lsn_req_ready = 1'b1; tick(); lsn_req_ready = 1'b0;
    chk(lsn_req_valid == 1'b0, "R1 single listen request", lsn_req_valid, 0);
    lsn_rsp_ok = 1'b1; lsn_rsp_valid = 1'b1;
    while (!lsn_rsp_ready) tick();
    chk(ntf_ready == 1'b0, "R9 no notification in listen response cycle", ntf_ready, 0);
    tick(); lsn_rsp_valid = 1'b0;
    chk(ntf_ready == 1'b1, "R9 notification ready next cycle", ntf_ready, 1);
    tick(); ntf_valid = 1'b0; busy = 1'b1;
    echo_body(1000, 16'h0101, 5, 1, 2);

    // R3 closed and empty notifications
    send_notif(16'h0202, 100, 1'b1, 1'b0);
    for (int i = 0; i < 6; i++) begin
      chk(rd_req_valid == 1'b0, "R3 closed notice ignored", rd_req_valid, 0);
      chk(ntf_ready == 1'b1, "R3 ready after closed notice", ntf_ready, 1);
      tick();
    end
    send_notif(16'h0303, 0, 1'b0, 1'b0);
    for (int i = 0; i < 6; i++) begin
      chk(rd_req_valid == 1'b0, "R3 empty notice ignored", rd_req_valid, 0);
      tick();
    end

    // Sweep of lengths: partial keeps, chunking (R4, R10), refusals and pauses (R7)
    for (int len = 1; len <= 40; len++) begin
      backoff_cycles = BOW'(len % 4);
      send_notif(16'(16'h0100 + len), len, 1'b0, 1'b1);
      echo_body(len, 16'(16'h0100 + len), len, len % 3, len % 4);
    end

    // R2 listen refusal
    rst = 1'b1; tick(); tick(); rst = 1'b0;
    chk(lsn_req_valid == 1'b1, "R1 listen request after second reset", lsn_req_valid, 1);
    lsn_req_ready = 1'b1; tick(); lsn_req_ready = 1'b0;
    lsn_rsp_ok = 1'b0; lsn_rsp_valid = 1'b1;
    while (!lsn_rsp_ready) tick();
    tick(); lsn_rsp_valid = 1'b0;
    ntf_session = 16'h0404; ntf_length = 16'd8; ntf_closed = 1'b0; ntf_valid = 1'b1;
    for (int i = 0; i < 20; i++) begin
      chk(listen_failed == 1'b1, "R2 failure sticky", listen_failed, 1);
      chk(ntf_ready == 1'b0 && lsn_req_valid == 1'b0, "R2 no traffic after failure",
          {ntf_ready, lsn_req_valid}, 0);
      tick();
    end
    ntf_valid = 1'b0;

    summary();
    $finish;
  end
endmodule